// File: doc/BRIEF.md
# Manchester Word Transmitter with Error Injection

This block turns a stream of queued words into a bi-phase serial line. Each queued entry carries a 16-bit payload, a choice between the command/status and data sync shapes, seven fault flags and a 4-bit bit index that the timing faults use. The block runs from a clock at twelve ticks per bit, so one bit lasts 12 ticks. For every entry it emits a three-bit-time sync, then the payload MSB first, then an odd parity bit. Entries that follow one another in the queue go out back to back with no gap. A message ends when the queue runs dry or sending is disabled at a word boundary.

The fault flags let a tester corrupt a chosen word on purpose. A flag can shorten the word by one bit, flip its parity, distort its sync, send the word a second time (so the data word count is wrong), move the crossing of one bit or of the sync by 4 ticks, or remove the crossing of one bit. After the last bit of a message, a completion flag is set and an interrupt pulse follows a fixed 24-tick wait.

The queue is external and shows its head word while it is not empty. The block pops the head with a one-cycle read strobe at the moment it takes the word.

Top module: `manchester_tx`

## Requirements
- R1: While send_en is low or the queue is empty at a word boundary, no entry is popped, tx_out is low and tx_active is low.
- R2: The entry layout is data[15:0], sync select [16] (1 = command/status), fault flags [23:17] and fault bit index [27:24]. A word is 36 sync ticks, then 16 data bits of 12 ticks each, MSB first, then a 12-tick parity bit. The command/status sync is 18 ticks high then 18 low, and the data sync is the inverse. A 1 is 6 ticks high then 6 low, and a 0 is the inverse.
- R3: The parity bit makes the number of ones in the 16 payload bits plus parity odd.
- R4: Each entry is popped exactly once, in queue order. A queued entry starts in the tick right after the previous parity bit, so tx_active stays high across the message.
- R5: Flag bit 17 (bit count) drops the last payload bit, so 15 data bits are sent. Parity is still computed over all 16.
- R6: Flag bit 18 (parity) inverts the parity bit that is sent.
- R7: Flag bit 19 (sync) makes the sync hold its first level for 12 ticks and the opposite level for 24.
- R8: Flag bit 20 (word count) sends the word twice back to back, with one pop.
- R9: Flag bit 21 (mid-bit) delays the crossing of the data bit at the fault index (0 = first sent) by 4 ticks: 10 ticks at its first level, then 2.
- R10: Flag bit 22 (mid-sync) delays the sync crossing by 4 ticks: 22 ticks, then 14.
- R11: Flag bit 23 (bi-phase) holds the data bit at the fault index at its first-half level for all 12 ticks. This flag takes precedence over R9.
- R12: tx_done rises and tx_irq pulses for exactly one cycle 24 ticks after tx_active falls. tx_done clears once a new message is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, 12 per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| send_en | input | 1 | Permission to start words |
| fifo_empty | input | 1 | Queue has no entry |
| fifo_rd_data | input | 28 | Head entry of the queue |
| fifo_rd_en | output | 1 | Pop strobe for the head entry |
| tx_out | output | 1 | Bi-phase serial line |
| tx_active | output | 1 | A word is being sent |
| tx_done | output | 1 | Message completed status |
| tx_irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with its defaults: 12 ticks per bit, a 4-tick crossing delay and a 24-tick completion wait. These values are small enough that a whole word, a three-word message and the completion window can be recorded tick by tick. Every line sample is compared with a waveform that the bench derives from the requirement text. The vectors reach each of the seven fault flags, fault indices at the first and an inner bit, payloads of mixed density, back-to-back words and a stall on send_en.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester word transmitter.
// Assumes a fixed 16-bit payload; the entry layout is decoded by the bench.
package mtx_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = $clog2(DATA_W);

    // One queued word with its fault controls (packed MSB first)
    typedef struct packed {
        logic [IDX_W-1:0]  err_bit;
        logic              e_biph;
        logic              e_midsync;
        logic              e_mid;
        logic              e_wcnt;
        logic              e_sync;
        logic              e_par;
        logic              e_bitcnt;
        logic              sync_cmd;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    localparam int ENTRY_W = $bits(tx_entry_t);

    typedef enum logic [1:0] {W_IDLE, W_SYNC, W_DATA, W_PAR} wave_st_e;
endpackage

// File: rtl/mtx_seq.sv
// Word sequencer: decides when the head queue entry is taken.
// Assumes a show-ahead queue; an entry is taken only when the
// waveform engine is free or finishing its parity bit.
module mtx_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic send_en,
    input  logic fifo_empty,
    input  logic can_take,
    output logic fifo_rd_en,
    output logic start
);
    // Take the head entry when allowed and available
    always_comb begin
        fifo_rd_en = can_take && send_en && !fifo_empty;
        start      = fifo_rd_en;
    end

    // R1: a pop never happens without permission and data
    p_pop_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> (send_en && !fifo_empty));
endmodule

// File: rtl/mtx_wave.sv
// Waveform engine: emits sync, payload bits and parity of one entry,
// with the fault controls applied per slot. Accepts a new entry on
// the last parity tick so words run back to back.
// Assumes TICKS_PER_BIT is even and MID_DELAY < TICKS_PER_BIT/2.
module mtx_wave
    import mtx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 12,
    parameter int MID_DELAY     = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  tx_entry_t entry_in,
    output logic      busy,
    output logic      word_end,
    output logic      tx_out
);
    localparam int HALF      = TICKS_PER_BIT / 2;
    localparam int SYNC_LEN  = 3 * TICKS_PER_BIT;
    localparam int SYNC_HALF = SYNC_LEN / 2;
    localparam int CNT_W     = $clog2(SYNC_LEN + 1);

    wave_st_e          st;
    logic [CNT_W-1:0]  tick;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] shreg;
    tx_entry_t         ent;
    logic              rep_done;

    logic [CNT_W-1:0]  slot_len, slot_half;
    logic              first, flat, hit, last_tick, repeat_now;
    logic [IDX_W-1:0]  last_idx;

    // Shape of the current slot: length, crossing point, first level
    always_comb begin
        hit       = (bidx == ent.err_bit);
        slot_len  = CNT_W'(TICKS_PER_BIT);
        slot_half = CNT_W'(HALF);
        first     = 1'b0;
        flat      = 1'b0;
        unique case (st)
            W_SYNC: begin
                slot_len = CNT_W'(SYNC_LEN);
                if (ent.e_sync)         slot_half = CNT_W'(TICKS_PER_BIT);
                else if (ent.e_midsync) slot_half = CNT_W'(SYNC_HALF + MID_DELAY);
                else                    slot_half = CNT_W'(SYNC_HALF);
                first = ent.sync_cmd;
            end
            W_DATA: begin
                if (ent.e_mid && hit) slot_half = CNT_W'(HALF + MID_DELAY);
                first = shreg[DATA_W-1];
                flat  = ent.e_biph && hit;
            end
            W_PAR:   first = ~(^ent.data) ^ ent.e_par;
            default: first = 1'b0;
        endcase
    end

    // Slot and word boundary decode
    always_comb begin
        last_tick  = (tick == slot_len - 1'b1);
        last_idx   = ent.e_bitcnt ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
        repeat_now = ent.e_wcnt && !rep_done;
        word_end   = (st == W_PAR) && last_tick && !repeat_now;
        busy       = (st != W_IDLE);
        tx_out     = busy && ((flat || (tick < slot_half)) ? first : ~first);
    end

    // Slot sequencing, tick counting and payload shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            tick     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            ent      <= '0;
            rep_done <= 1'b0;
        end else if (start) begin
            ent      <= entry_in;
            shreg    <= entry_in.data;
            st       <= W_SYNC;
            tick     <= '0;
            bidx     <= '0;
            rep_done <= 1'b0;
        end else if (st != W_IDLE) begin
            if (!last_tick) begin
                tick <= tick + 1'b1;
            end else begin
                tick <= '0;
                unique case (st)
                    W_SYNC: st <= W_DATA;
                    W_DATA: begin
                        if (bidx == last_idx) st <= W_PAR;
                        else begin
                            bidx  <= bidx + 1'b1;
                            shreg <= shreg << 1;
                        end
                    end
                    W_PAR: begin
                        if (repeat_now) begin
                            st       <= W_SYNC;
                            bidx     <= '0;
                            shreg    <= ent.data;
                            rep_done <= 1'b1;
                        end else begin
                            st <= W_IDLE;
                        end
                    end
                    default: st <= W_IDLE;
                endcase
            end
        end
    end

    // R1: the line rests low outside a word
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE) |-> !tx_out);
    // R4: a new entry is only accepted when the engine can take it
    p_start_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((st == W_IDLE) || word_end));
    // R2: inside a data bit the line only moves at the crossing
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_DATA && tick != '0 && tick != slot_half) |-> (tx_out == $past(tx_out)));
endmodule

// File: rtl/mtx_done.sv
// Completion timer: after a message ends, waits DONE_TICKS ticks,
// then sets the completion flag and pulses the interrupt once.
// Assumes busy is low only between messages.
module mtx_done #(
    parameter int DONE_TICKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic done,
    output logic irq
);
    localparam int DW = $clog2(DONE_TICKS + 1);

    logic [DW-1:0] cnt;
    logic          armed;

    // Count idle ticks after a message and raise completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
            done  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (busy) begin
                cnt   <= '0;
                armed <= 1'b1;
                done  <= 1'b0;
            end else if (armed) begin
                if (cnt == DW'(DONE_TICKS - 1)) begin
                    done  <= 1'b1;
                    irq   <= 1'b1;
                    armed <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R12: interrupt is a single-cycle pulse
    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R12: completion is never raised while the line is in use
    p_irq_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && done));
    // R12: an active message clears completion
    p_done_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !done);
endmodule

// File: rtl/manchester_tx.sv
// Top of the Manchester word transmitter with fault injection.
// Joins the sequencer, waveform engine and completion timer.
// Assumes a show-ahead queue whose head is valid while not empty.
module manchester_tx
    import mtx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 12,
    parameter int MID_DELAY     = 4,
    parameter int DONE_TICKS    = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               send_en,
    input  logic               fifo_empty,
    input  logic [ENTRY_W-1:0] fifo_rd_data,
    output logic               fifo_rd_en,
    output logic               tx_out,
    output logic               tx_active,
    output logic               tx_done,
    output logic               tx_irq
);
    tx_entry_t head;
    logic      start, busy, word_end, can_take;

    // Decode the head entry and the take window
    always_comb begin
        head     = tx_entry_t'(fifo_rd_data);
        can_take = !busy || word_end;
    end

    mtx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .send_en    (send_en),
        .fifo_empty (fifo_empty),
        .can_take   (can_take),
        .fifo_rd_en (fifo_rd_en),
        .start      (start)
    );

    mtx_wave #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .MID_DELAY     (MID_DELAY)
    ) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .entry_in (head),
        .busy     (busy),
        .word_end (word_end),
        .tx_out   (tx_out)
    );

    mtx_done #(
        .DONE_TICKS (DONE_TICKS)
    ) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .done  (tx_done),
        .irq   (tx_irq)
    );

    assign tx_active = busy;
endmodule

// File: tb/sim_manchester_tx.sv
module sim_manchester_tx;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 12;
    localparam int MIDD       = 4;
    localparam int DONE_T     = 24;
    localparam int CAP_MAX    = 8192;

    localparam logic [6:0] F_NONE    = 7'b0000000;
    localparam logic [6:0] F_BITCNT  = 7'b0000001;
    localparam logic [6:0] F_PAR     = 7'b0000010;
    localparam logic [6:0] F_SYNC    = 7'b0000100;
    localparam logic [6:0] F_WCNT    = 7'b0001000;
    localparam logic [6:0] F_MID     = 7'b0010000;
    localparam logic [6:0] F_MIDSYNC = 7'b0100000;
    localparam logic [6:0] F_BIPH    = 7'b1000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        send_en = 1'b0;
    logic        fifo_empty;
    logic [27:0] fifo_rd_data;
    logic        fifo_rd_en, tx_out, tx_active, tx_done, tx_irq;

    int checks = 0;
    int fails  = 0;

    logic [27:0] fmem [0:63];
    int wp = 0;
    int rp;

    logic capv [0:CAP_MAX-1];
    logic expv [0:CAP_MAX-1];
    int   caplen, explen;
    logic done_at1;
    logic [27:0] msg [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Show-ahead queue model
    assign fifo_empty   = (rp == wp);
    assign fifo_rd_data = fmem[rp[5:0]];
    always @(posedge clk) begin
        if (!rst_n) rp <= 0;
        else if (fifo_rd_en) rp <= rp + 1;
    end

    manchester_tx #(.TICKS_PER_BIT(TPB), .MID_DELAY(MIDD), .DONE_TICKS(DONE_T)) u0 (
        .clk(clk), .rst_n(rst_n), .send_en(send_en), .fifo_empty(fifo_empty),
        .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en), .tx_out(tx_out),
        .tx_active(tx_active), .tx_done(tx_done), .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expd);
        end
    endtask

    function automatic logic [27:0] mk(input logic [15:0] d, input logic cmd,
                                       input logic [6:0] fl, input logic [3:0] eb);
        return {eb, fl, cmd, d};
    endfunction

    task automatic seg(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            expv[explen] = lvl;
            explen++;
        end
    endtask

    // Expected line waveform of one entry, from the requirements
    task automatic add_word(input logic [27:0] e);
        logic first, b, par;
        int sh, nb, h;
        first = e[16];
        sh = e[19] ? TPB : (e[22] ? 18 + MIDD : 18);
        seg(first, sh);
        seg(!first, 3*TPB - sh);
        nb = e[17] ? 15 : 16;
        for (int i = 0; i < nb; i++) begin
            b = e[15-i];
            if (e[23] && (e[27:24] == 4'(i))) seg(b, TPB);
            else begin
                h = (e[21] && (e[27:24] == 4'(i))) ? TPB/2 + MIDD : TPB/2;
                seg(b, h);
                seg(!b, TPB - h);
            end
        end
        par = ~(^e[15:0]) ^ e[18];
        seg(par, TPB/2);
        seg(!par, TPB/2);
        if (e[20] && !e[31-4]) begin end
    endtask

    // Push n entries, send them, compare the line and completion timing
    task automatic run_msg(input string req, input int n);
        int k, bad, rp0;
        explen = 0;
        rp0 = rp;
        for (int i = 0; i < n; i++) begin
            fmem[wp[5:0]] = msg[i];
            wp = wp + 1;
            add_word(msg[i]);
            if (msg[i][20]) add_word(msg[i]);
        end
        @(negedge clk);
        send_en = 1'b1;
        k = 0;
        while (!tx_active && k < 200) begin @(negedge clk); k++; end
        caplen = 0;
        done_at1 = 1'b1;
        while (tx_active && caplen < CAP_MAX) begin
            capv[caplen] = tx_out;
            if (caplen == 1) done_at1 = tx_done;
            caplen++;
            @(negedge clk);
        end
        send_en = 1'b0;
        chk(caplen == explen, {req, " word length in ticks"}, caplen, explen);
        bad = -1;
        for (int i = 0; i < caplen && i < explen; i++)
            if (bad < 0 && capv[i] !== expv[i]) bad = i;
        chk(bad < 0, {req, " line level mismatch at tick"}, bad, -1);
        chk(rp - rp0 == n, "R4 entries popped", rp - rp0, n);
        chk(done_at1 == 1'b0, "R12 done cleared while active", int'(done_at1), 0);
        k = 0;
        while (!tx_irq && k < 100) begin @(negedge clk); k++; end
        chk(k == DONE_T, "R12 irq delay after last bit", k, DONE_T);
        @(negedge clk);
        chk(!tx_irq && tx_done, "R12 irq single pulse, done held", int'({tx_irq, tx_done}), 1);
    endtask

    task automatic t_reset;
        chk(!tx_out && !tx_active && !tx_done && !tx_irq && !fifo_rd_en,
            "R1 reset outputs", int'({tx_out, tx_active, tx_done, tx_irq, fifo_rd_en}), 0);
    endtask

    task automatic t_plain_cmd;
        msg[0] = mk(16'hC35A, 1'b1, F_NONE, 4'd0);
        run_msg("R2 R3 command word", 1);
    endtask

    task automatic t_message;
        msg[0] = mk(16'h0841, 1'b1, F_NONE, 4'd0);
        msg[1] = mk(16'hFFFF, 1'b0, F_NONE, 4'd0);
        msg[2] = mk(16'h0000, 1'b0, F_NONE, 4'd0);
        run_msg("R4 back-to-back message", 3);
    endtask

    task automatic t_enable_hold;
        int seen;
        msg[0] = mk(16'h1234, 1'b0, F_NONE, 4'd0);
        fmem[wp[5:0]] = msg[0];
        wp = wp + 1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_active || tx_out) seen++;
        end
        chk(seen == 0, "R1 no line activity with send_en low", seen, 0);
        chk(!fifo_empty, "R1 entry not popped with send_en low", int'(fifo_empty), 0);
        wp = wp - 1;
        run_msg("R1 R2 data word after enable", 1);
    endtask

    task automatic t_parity;
        msg[0] = mk(16'h7001, 1'b1, F_PAR, 4'd0);
        run_msg("R6 parity fault", 1);
    endtask

    task automatic t_sync;
        msg[0] = mk(16'h00F0, 1'b0, F_SYNC, 4'd0);
        run_msg("R7 sync fault", 1);
    endtask

    task automatic t_bitcnt;
        msg[0] = mk(16'hA5A5, 1'b1, F_BITCNT, 4'd0);
        run_msg("R5 bit count fault", 1);
    endtask

    task automatic t_wcnt;
        msg[0] = mk(16'h2222, 1'b1, F_NONE, 4'd0);
        msg[1] = mk(16'h9C3E, 1'b0, F_WCNT, 4'd0);
        run_msg("R8 word count fault", 2);
    endtask

    task automatic t_mid;
        msg[0] = mk(16'hA5C3, 1'b0, F_MID, 4'd3);
        run_msg("R9 mid-bit delay", 1);
    endtask

    task automatic t_midsync;
        msg[0] = mk(16'h5555, 1'b1, F_MIDSYNC, 4'd0);
        run_msg("R10 mid-sync delay", 1);
    endtask

    task automatic t_biph;
        msg[0] = mk(16'h8001, 1'b0, F_BIPH | F_MID, 4'd0);
        run_msg("R11 bi-phase fault", 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_cmd();
        t_message();
        t_enable_hold();
        t_parity();
        t_sync();
        t_bitcnt();
        t_wcnt();
        t_mid();
        t_midsync();
        t_biph();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule